// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a small binary up-counter in which every state bit changes on the same rising clock edge. At each edge a fixed priority picks one action. An active-low clear forces zero. Otherwise an active-low load copies a parallel data word. Otherwise the counter increments, but only when both active-high count enables are high. If none of these applies, the count holds.

Only one of the two enables, the carry-gating enable, also controls the ripple-carry output. That output is high while the count is all ones and the carry-gating enable is high. Because it is plain combinational logic, it can drive the carry-gating enable of the next stage directly. Identical stages can therefore be chained into a wider synchronous counter with the plain enable shared by all stages. A decode of a chosen terminal value fed back into the clear input gives a counter with a shorter modulus. The count width is a parameter and defaults to four bits. The state is undefined at power-up until the first clear or load.

Top module: `sync_bin_counter`

## Requirements
- R1: The stored count changes only at a rising clock edge, with all bits updating together. Pulses on the enables or the load input between edges leave the count unchanged.
- R2: When clr_n is low at a rising edge, the count becomes zero on that edge, whatever load_n, enp, ent and d are.
- R3: When clr_n is high and load_n is low at a rising edge, the count takes the value of d on that edge, whatever enp and ent are.
- R4: When clr_n and load_n are high and enp and ent are both high at an edge, the count rises by one. All ones (15 for the default width) wraps to zero.
- R5: When clr_n and load_n are high and at least one of enp and ent is low at an edge, the count holds its value.
- R6: rco is 1 exactly when ent is 1 and the count is all ones. enp has no effect on rco.
- R7: rco is combinational from the count and ent. It follows a change on ent within the same clock cycle, with no edge needed.
- R8: In a chain of two stages, the lower stage's rco drives the upper stage's ent and enp is shared. The 8-bit value {upper q, lower q} then counts through 0 to 255 and wraps to 0.
- R9: With clr_n driven low by a decode of count value 9, the counter runs 0 through 9 and returns to 0 on the edge after 9, giving a modulus of 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all state bits |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| enp | input | 1 | Count enable that does not gate the carry |
| ent | input | 1 | Count enable that also gates rco |
| d | input | WIDTH | Parallel load value |
| q | output | WIDTH | Current count |
| rco | output | 1 | Ripple carry: ent high and count all ones |

## Verification
Load, clear, increment and hold are swept over every count value and every combination of the enables, so all priority cases are covered.
- A design that let load beat clear would leave the loaded value instead of zero.
- A design that let the enables gate the load would hold the old value.
- A carry chain that stopped short would wrap at the wrong count or fail to carry from 7 to 8.

The carry output is checked against enp, which it must ignore, and against ent mid-cycle, where a registered carry would lag by one cycle. The bench also checks three system-level behaviours:
- Pulses on the control inputs between edges, which a level-sensitive design would latch.
- A two-stage chain run through all 256 values, where a late or enp-gated carry would skip or double-count the upper stage.
- A clear-decoded modulus-10 loop that must return to zero exactly one edge after 9.

// File: rtl/sbc_pkg.sv
// Shared types for the synchronous binary counter.
// Assumes nothing beyond a standard SystemVerilog package scope.
package sbc_pkg;

    // Action selected for the next rising edge, listed from lowest to highest priority.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } sbc_op_t;

endpackage

// File: rtl/sbc_op_select.sv
// Priority selector: clear beats load, load beats count, and hold is the default.
// Assumes all inputs are sampled together by the state register.
module sbc_op_select
    import sbc_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    enp,
    input  logic    ent,
    output sbc_op_t op
);

    // Resolve the control inputs into a single action.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (enp && ent) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/sbc_next_state.sv
// Next-count logic with a lookahead increment: bit i toggles when all lower bits are one.
// Assumes that op has already been resolved by priority.
module sbc_next_state
    import sbc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  sbc_op_t          op,
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] nxt
);

    logic [WIDTH:0]   ones_below;
    logic [WIDTH-1:0] incremented;

    assign ones_below[0] = 1'b1;

    // One toggle term per bit, taken from the AND of all lower bits.
    for (genvar i = 0; i < WIDTH; i++) begin : g_lookahead
        assign ones_below[i+1] = ones_below[i] & q[i];
        assign incremented[i]  = q[i] ^ ones_below[i];
    end

    // Choose the next count for the selected action.
    always_comb begin
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = d;
            OP_COUNT: nxt = incremented;
            default:  nxt = q;
        endcase
    end

endmodule

// File: rtl/sbc_carry.sv
// Ripple-carry generator: high while ent is high and the count is all ones.
// Assumes the output may drive the ent input of a following stage directly.
module sbc_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             ent,
    output logic             rco
);

    // Purely combinational terminal-count detect, gated by ent.
    always_comb begin
        rco = ent & (&q);
    end

endmodule

// File: rtl/sync_bin_counter.sv
// Top level: presettable synchronous binary counter stage that can be cascaded.
// Assumes a single clock. Initialisation happens only through clr_n or load_n,
// so the state is undefined until then.
module sync_bin_counter
    import sbc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             enp,
    input  logic             ent,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             rco
);

    sbc_op_t          op;
    logic [WIDTH-1:0] count_r;
    logic [WIDTH-1:0] count_nxt;

    sbc_op_select u_op_select (
        .clr_n  (clr_n),
        .load_n (load_n),
        .enp    (enp),
        .ent    (ent),
        .op     (op)
    );

    sbc_next_state #(.WIDTH(WIDTH)) u_next_state (
        .op  (op),
        .q   (count_r),
        .d   (d),
        .nxt (count_nxt)
    );

    sbc_carry #(.WIDTH(WIDTH)) u_carry (
        .q   (count_r),
        .ent (ent),
        .rco (rco)
    );

    // All state bits update together on the rising edge. The synchronous clear is part of count_nxt.
    always_ff @(posedge clk) begin
        count_r <= count_nxt;
    end

    assign q = count_r;

endmodule

// File: rtl/sbc_checker.sv
// Checker for sync_bin_counter. Properties stay disabled until the first clear or load
// has defined the state.
module sbc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             enp,
    input logic             ent,
    input logic [WIDTH-1:0] d,
    input logic [WIDTH-1:0] q,
    input logic             rco
);

    logic seen = 1'b0;

    // Record that the count has been defined by a clear or a load.
    always_ff @(posedge clk) begin
        if (!clr_n || !load_n) begin
            seen <= 1'b1;
        end
    end

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!seen)
        !clr_n |=> (q == '0));

    p_load_data_r3: assert property (@(posedge clk) disable iff (!seen)
        (clr_n && !load_n) |=> (q == $past(d)));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!seen)
        (clr_n && load_n && enp && ent) |=> (q == WIDTH'($past(q) + 1'b1)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!seen)
        (clr_n && load_n && !(enp && ent)) |=> $stable(q));

    p_carry_needs_ent_r6: assert property (@(posedge clk) disable iff (!seen)
        rco |-> (ent && (q == {WIDTH{1'b1}})));

    p_carry_at_top_r6: assert property (@(posedge clk) disable iff (!seen)
        (ent && (q == {WIDTH{1'b1}})) |-> rco);

endmodule

bind sync_bin_counter sbc_checker #(.WIDTH(WIDTH)) u_sbc_checker (
    .clk    (clk),
    .clr_n  (clr_n),
    .load_n (load_n),
    .enp    (enp),
    .ent    (ent),
    .d      (d),
    .q      (q),
    .rco    (rco)
);

// File: tb/sync_bin_counter_bench.sv
// Self-checking bench: sweeps a single stage, a two-stage chain and a modulus-10 loop.
module sync_bin_counter_bench;

    localparam int W = 4;
    localparam int TOP = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         load_n = 1'b1;
    logic         enp = 1'b0;
    logic         ent = 1'b0;
    logic [W-1:0] d = '0;
    logic [W-1:0] q_lo, q_hi, q_m;
    logic         rco_lo, rco_hi, rco_m;
    logic         clr_m_n;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sync_bin_counter #(.WIDTH(W)) u_sync_bin_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .enp(enp), .ent(ent),
        .d(d), .q(q_lo), .rco(rco_lo)
    );

    // Upper stage of the chain: its ent is the lower stage's carry.
    sync_bin_counter #(.WIDTH(W)) u_upper (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .enp(enp), .ent(rco_lo),
        .d(d), .q(q_hi), .rco(rco_hi)
    );

    // Modulus-10 counter: decode of 9 drives its clear.
    assign clr_m_n = clr_n & (q_m != W'(9));
    sync_bin_counter #(.WIDTH(W)) u_modulus (
        .clk(clk), .clr_n(clr_m_n), .load_n(1'b1), .enp(enp), .ent(ent),
        .d('0), .q(q_m), .rco(rco_m)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ctl(input logic c, input logic l, input logic p, input logic t,
                           input logic [W-1:0] v);
        clr_n = c; load_n = l; enp = p; ent = t; d = v;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #1;
        // Reset state via clear.
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0, '0);
        tick();
        check("R2 reset clear", q_lo, 0);

        // R3: load every value under every enable combination.
        for (int v = 0; v <= TOP; v++) begin
            for (int e = 0; e < 4; e++) begin
                set_ctl(1'b1, 1'b0, e[0], e[1], W'(v));
                tick();
                check("R3 load", q_lo, v);
            end
        end

        // R2: clear beats load and enables from every value.
        for (int v = 0; v <= TOP; v++) begin
            set_ctl(1'b1, 1'b0, 1'b0, 1'b0, W'(v));
            tick();
            set_ctl(1'b0, 1'b0, 1'b1, 1'b1, W'(TOP - v));
            tick();
            check("R2 clear priority", q_lo, 0);
        end

        // R4: increment with wrap, from every value.
        for (int v = 0; v <= TOP; v++) begin
            set_ctl(1'b1, 1'b0, 1'b0, 1'b0, W'(v));
            tick();
            set_ctl(1'b1, 1'b1, 1'b1, 1'b1, '0);
            tick();
            check("R4 increment", q_lo, (v + 1) % (TOP + 1));
        end

        // R5 hold and R6 carry, from every value and enable combination.
        for (int v = 0; v <= TOP; v++) begin
            set_ctl(1'b1, 1'b0, 1'b0, 1'b0, W'(v));
            tick();
            for (int e = 0; e < 4; e++) begin
                set_ctl(1'b1, 1'b1, e[0], e[1], W'(~v));
                #0.5;
                check("R6 carry", rco_lo, (e[1] && v == TOP) ? 1 : 0);
                if (e != 3) begin
                    tick();
                    check("R5 hold", q_lo, v);
                end
            end
        end

        // R7: rco follows ent mid-cycle at all ones.
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0, W'(TOP));
        tick();
        set_ctl(1'b1, 1'b1, 1'b0, 1'b1, '0);
        #0.5;
        check("R7 rco rises with ent", rco_lo, 1);
        ent = 1'b0;
        #0.5;
        check("R7 rco falls with ent", rco_lo, 0);

        // R1: pulses between edges have no effect.
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0, W'(5));
        tick();
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0, W'(9));
        #0.5; load_n = 1'b0; enp = 1'b1; ent = 1'b1;
        #0.5; load_n = 1'b1; enp = 1'b0; ent = 1'b0;
        #0.3;
        check("R1 no change between edges", q_lo, 5);
        tick();
        check("R1 edge sample only", q_lo, 5);

        // R8: two-stage chain through 256 values and the wrap.
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0, '0);
        tick();
        check("R8 chain cleared", {q_hi, q_lo}, 0);
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, '0);
        for (int i = 1; i <= 257; i++) begin
            tick();
            check("R8 chain count", {q_hi, q_lo}, i % 256);
        end

        // R9: modulus-10 loop by clear decode.
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0, '0);
        tick();
        check("R9 modulus cleared", q_m, 0);
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, '0);
        for (int i = 1; i <= 25; i++) begin
            tick();
            check("R9 modulus ten", q_m, i % 10);
        end

        finish_run();
    end

endmodule